// File: doc/BRIEF.md
# Repeat and Loop Counter Unit

This block keeps the two iteration counters of a port controller's instruction pipeline. The repeat counter governs how many times a repeating instruction fires, and it can also be put into an unbounded (infinite) state. The loop counter governs how many times a group of instructions is re-issued. Each counter can be loaded from a short literal carried in the instruction or from the low bits of the data word. The loop counter also takes a saturating decrement command, and it has a clear input that forces it to zero when the current instruction is killed.

The unit drives out the counter values, a loop-at-zero flag, and a repeat-continue flag that the issue logic uses to decide whether to fire a repeating instruction again. It also drives two read-back words. Each one is the incoming data word with its low bits replaced by one of the counters, ready to be written back into the data latch. Instruction queueing and issue decisions are made outside this block.

Top module: `rl_counter_unit`

## Requirements
- R1: After reset, the repeat count is 0 and not infinite, the loop count is 0, `lc_zero` is 1 and `rep_continue` is 0.
- R2: `rep_cmd` is decoded as 00 none, 01 literal, 10 data, 11 infinity. At the next clock edge, 01 loads `lit_in` zero-extended and 10 loads the low `CNT_W` bits of `data_in`, and both of these clear the infinite state. 11 sets `rc_inf`, and while `rc_inf` is set, `rc_value` reads as all ones.
- R3: With `rep_cmd` = 00 and `rep_step` = 1, a finite repeat count above zero drops by one and a count of zero stays at zero.
- R4: While infinite, `rep_step` leaves both `rc_inf` and `rc_value` unchanged.
- R5: `rep_continue` is 1 exactly when the repeat counter is infinite or its count is nonzero.
- R6: When a repeat load and `rep_step` arrive in the same cycle, the load takes effect and the step is dropped.
- R7: With `rep_cmd` = 00 and `rep_step` = 0, the repeat counter holds its value, whatever the loop inputs are.
- R8: `loop_cmd` is decoded as 00 none, 01 decrement, 10 literal, 11 data. Decrement gives max(count-1, 0). Literal loads `lit_in` zero-extended. Data loads the low `CNT_W` bits of `data_in`.
- R9: `loop_clear` makes the loop count 0 at the next edge and overrides any `loop_cmd` in the same cycle.
- R10: `lc_zero` is 1 exactly when the loop count is 0.
- R11: `rd_loop_word` and `rd_rep_word` equal `data_in` with bits [CNT_W-1:0] replaced by the loop count and by `rc_value` respectively. The remaining bits pass through unchanged, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_cmd | input | 2 | Repeat counter load command |
| rep_step | input | 1 | One execution of a repeating instruction |
| loop_cmd | input | 2 | Loop counter command |
| loop_clear | input | 1 | Force loop counter to zero |
| lit_in | input | LIT_W | Literal operand |
| data_in | input | DATA_W | Data word operand and read-back base |
| rc_value | output | CNT_W | Repeat count (all ones when infinite) |
| rc_inf | output | 1 | Repeat counter is infinite |
| rep_continue | output | 1 | Repeating instruction may fire again |
| lc_value | output | CNT_W | Loop count |
| lc_zero | output | 1 | Loop count is zero |
| rd_rep_word | output | DATA_W | Data word with repeat count in its low bits |
| rd_loop_word | output | DATA_W | Data word with loop count in its low bits |

## Verification
The bound checker tests the following on every cycle:
- decrement and floor behaviour of both counters;
- the infinite state holding under steps;
- the repeat counter holding when idle;
- a clear winning over loads;
- literal loads reaching the loop counter.

Some behaviour needs the bench's reference model, which runs cycle by cycle. This covers priority between a load and a step in the same cycle, data loads truncating to the low bits, infinity being cleared by a finite load, and the exact read-back words under long random command mixes.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
   typedef enum logic [1:0] {
      REP_NONE = 2'b00,
      REP_LIT  = 2'b01,
      REP_DATA = 2'b10,
      REP_INF  = 2'b11
   } rep_cmd_e;

   typedef enum logic [1:0] {
      LOOP_NONE = 2'b00,
      LOOP_DEC  = 2'b01,
      LOOP_LIT  = 2'b10,
      LOOP_DATA = 2'b11
   } loop_cmd_e;
endpackage

// File: rtl/rlc_rep_counter.sv
module rlc_rep_counter
   import rlc_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int LIT_W  = 6,
   parameter int DATA_W = 37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rep_cmd_e          cmd,
   input  logic              step,
   input  logic [LIT_W-1:0]  lit,
   input  logic [DATA_W-1:0] data,
   output logic [CNT_W-1:0]  count,
   output logic              inf
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             inf_q, inf_d;

   always_comb begin
      cnt_d = cnt_q;
      inf_d = inf_q;
      unique case (cmd)
         REP_LIT: begin
            cnt_d = CNT_W'(lit);
            inf_d = 1'b0;
         end
         REP_DATA: begin
            cnt_d = data[CNT_W-1:0];
            inf_d = 1'b0;
         end
         REP_INF: begin
            cnt_d = ALL_ONES;
            inf_d = 1'b1;
         end
         default: begin
            if (step && !inf_q && (cnt_q != '0))
               cnt_d = cnt_q - 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         inf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         inf_q <= inf_d;
      end
   end

   assign count = cnt_q;
   assign inf   = inf_q;
endmodule

// File: rtl/rlc_loop_counter.sv
module rlc_loop_counter
   import rlc_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int LIT_W  = 6,
   parameter int DATA_W = 37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  loop_cmd_e         cmd,
   input  logic              clear,
   input  logic [LIT_W-1:0]  lit,
   input  logic [DATA_W-1:0] data,
   output logic [CNT_W-1:0]  count,
   output logic              zero
);
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clear) begin
         cnt_d = '0;
      end else begin
         unique case (cmd)
            LOOP_DEC:  if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            LOOP_LIT:  cnt_d = CNT_W'(lit);
            LOOP_DATA: cnt_d = data[CNT_W-1:0];
            default:   cnt_d = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count = cnt_q;
   assign zero  = (cnt_q == '0);
endmodule

// File: rtl/rlc_readback.sv
module rlc_readback #(
   parameter int CNT_W  = 6,
   parameter int DATA_W = 37
) (
   input  logic [DATA_W-1:0] base,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] word
);
   generate
      if (DATA_W == CNT_W) begin : g_full
         assign word = cnt;
      end else begin : g_merge
         assign word = {base[DATA_W-1:CNT_W], cnt};
      end
   endgenerate
endmodule

// File: rtl/rl_counter_unit.sv
module rl_counter_unit
   import rlc_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int LIT_W  = 6,
   parameter int DATA_W = 37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rep_cmd,
   input  logic              rep_step,
   input  logic [1:0]        loop_cmd,
   input  logic              loop_clear,
   input  logic [LIT_W-1:0]  lit_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CNT_W-1:0]  rc_value,
   output logic              rc_inf,
   output logic              rep_continue,
   output logic [CNT_W-1:0]  lc_value,
   output logic              lc_zero,
   output logic [DATA_W-1:0] rd_rep_word,
   output logic [DATA_W-1:0] rd_loop_word
);
   generate
      if (CNT_W < 1)       begin : g_bad_cnt  $error("CNT_W must be at least 1");      end
      if (LIT_W > CNT_W)   begin : g_bad_lit  $error("LIT_W must not exceed CNT_W");   end
      if (DATA_W < CNT_W)  begin : g_bad_data $error("DATA_W must be at least CNT_W"); end
   endgenerate

   rlc_rep_counter #(.CNT_W(CNT_W), .LIT_W(LIT_W), .DATA_W(DATA_W)) u_rep (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (rep_cmd_e'(rep_cmd)),
      .step  (rep_step),
      .lit   (lit_in),
      .data  (data_in),
      .count (rc_value),
      .inf   (rc_inf)
   );

   rlc_loop_counter #(.CNT_W(CNT_W), .LIT_W(LIT_W), .DATA_W(DATA_W)) u_loop (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (loop_cmd_e'(loop_cmd)),
      .clear (loop_clear),
      .lit   (lit_in),
      .data  (data_in),
      .count (lc_value),
      .zero  (lc_zero)
   );

   assign rep_continue = rc_inf || (rc_value != '0);

   rlc_readback #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rb_rep (
      .base (data_in),
      .cnt  (rc_value),
      .word (rd_rep_word)
   );

   rlc_readback #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rb_loop (
      .base (data_in),
      .cnt  (lc_value),
      .word (rd_loop_word)
   );
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
   parameter int CNT_W  = 6,
   parameter int LIT_W  = 6,
   parameter int DATA_W = 37
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        rep_cmd,
   input logic              rep_step,
   input logic [1:0]        loop_cmd,
   input logic              loop_clear,
   input logic [LIT_W-1:0]  lit_in,
   input logic [CNT_W-1:0]  rc_value,
   input logic              rc_inf,
   input logic [CNT_W-1:0]  lc_value
);
   p_inf_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rep_cmd == 2'b11 |=> rc_inf);

   p_rep_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_cmd == 2'b00 && rep_step && !rc_inf && rc_value != '0)
      |=> rc_value == $past(rc_value) - 1'b1);

   p_rep_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_cmd == 2'b00 && rep_step && !rc_inf && rc_value == '0)
      |=> rc_value == '0 && !rc_inf);

   p_inf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_cmd == 2'b00 && rc_inf) |=> rc_inf && $stable(rc_value));

   p_rep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_cmd == 2'b00 && !rep_step) |=> $stable(rc_value) && $stable(rc_inf));

   p_loop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_cmd == 2'b01 && !loop_clear && lc_value != '0)
      |=> lc_value == $past(lc_value) - 1'b1);

   p_loop_lit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_cmd == 2'b10 && !loop_clear) |=> lc_value == CNT_W'($past(lit_in)));

   p_loop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_clear |=> lc_value == '0);
endmodule

bind rl_counter_unit rlc_checker #(.CNT_W(CNT_W), .LIT_W(LIT_W), .DATA_W(DATA_W)) u_rlc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rep_cmd    (rep_cmd),
   .rep_step   (rep_step),
   .loop_cmd   (loop_cmd),
   .loop_clear (loop_clear),
   .lit_in     (lit_in),
   .rc_value   (rc_value),
   .rc_inf     (rc_inf),
   .lc_value   (lc_value)
);

// File: tb/rl_counter_unit_bench.sv
`timescale 1ns/1ps
module rl_counter_unit_bench;
   localparam int CNT_W  = 6;
   localparam int LIT_W  = 6;
   localparam int DATA_W = 37;
   localparam longint MAXV = (64'd1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        rep_cmd = '0;
   logic              rep_step = 1'b0;
   logic [1:0]        loop_cmd = '0;
   logic              loop_clear = 1'b0;
   logic [LIT_W-1:0]  lit_in = '0;
   logic [DATA_W-1:0] data_in = '0;
   logic [CNT_W-1:0]  rc_value, lc_value;
   logic              rc_inf, rep_continue, lc_zero;
   logic [DATA_W-1:0] rd_rep_word, rd_loop_word;

   always #2 clk = ~clk;

   rl_counter_unit #(.CNT_W(CNT_W), .LIT_W(LIT_W), .DATA_W(DATA_W)) u_rl_counter_unit (
      .clk(clk), .rst_n(rst_n), .rep_cmd(rep_cmd), .rep_step(rep_step),
      .loop_cmd(loop_cmd), .loop_clear(loop_clear), .lit_in(lit_in), .data_in(data_in),
      .rc_value(rc_value), .rc_inf(rc_inf), .rep_continue(rep_continue),
      .lc_value(lc_value), .lc_zero(lc_zero),
      .rd_rep_word(rd_rep_word), .rd_loop_word(rd_loop_word)
   );

   int     n_cmp = 0;
   int     n_bad = 0;
   bit     done  = 0;
   longint m_rc = 0, m_lc = 0;
   bit     m_inf = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic longint exp_rc();
      return m_inf ? MAXV : m_rc;
   endfunction

   task automatic compare_all();
      longint hi;
      hi = longint'(data_in) & ~MAXV;
      chk("R3 rc_value", rc_value, exp_rc());
      chk("R4 rc_inf", rc_inf, m_inf);
      chk("R5 rep_continue", rep_continue, (m_inf || m_rc != 0));
      chk("R8 lc_value", lc_value, m_lc);
      chk("R10 lc_zero", lc_zero, (m_lc == 0));
      chk("R11 rd_rep_word", rd_rep_word, hi | exp_rc());
      chk("R11 rd_loop_word", rd_loop_word, hi | m_lc);
   endtask

   task automatic step_once(input logic [1:0] rc_c, input logic st, input logic [1:0] lc_c,
                            input logic clr, input logic [LIT_W-1:0] lit, input logic [DATA_W-1:0] dat);
      @(negedge clk);
      rep_cmd = rc_c; rep_step = st; loop_cmd = lc_c; loop_clear = clr;
      lit_in = lit; data_in = dat;
      case (rc_c)
         2'b01: begin m_rc = lit; m_inf = 0; end
         2'b10: begin m_rc = longint'(dat) & MAXV; m_inf = 0; end
         2'b11: begin m_rc = MAXV; m_inf = 1; end
         default: if (st && !m_inf && m_rc > 0) m_rc--;
      endcase
      if (clr) m_lc = 0;
      else case (lc_c)
         2'b01: if (m_lc > 0) m_lc--;
         2'b10: m_lc = lit;
         2'b11: m_lc = longint'(dat) & MAXV;
         default: ;
      endcase
      @(posedge clk); #1;
      compare_all();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk("R1 rc_value", rc_value, 0);
      chk("R1 rc_inf", rc_inf, 0);
      chk("R1 lc_value", lc_value, 0);
      chk("R1 lc_zero", lc_zero, 1);
      chk("R1 rep_continue", rep_continue, 0);
      compare_all();

      // R2 literal load, then R3 countdown to floor
      step_once(2'b01, 0, 2'b00, 0, 6'd3, '0);
      chk("R2 literal load", rc_value, 3);
      repeat (4) step_once(2'b00, 1, 2'b00, 0, '0, '0);
      chk("R3 floor at zero", rc_value, 0);
      chk("R5 stop at zero", rep_continue, 0);

      // R2 infinity load, R4 sticky
      step_once(2'b11, 0, 2'b00, 0, '0, '0);
      chk("R2 infinity flag", rc_inf, 1);
      repeat (3) step_once(2'b00, 1, 2'b00, 0, '0, '0);
      chk("R4 infinity held", rc_inf, 1);
      chk("R4 infinity value", rc_value, MAXV);

      // R2 data load clears infinity, truncates to low bits
      step_once(2'b10, 0, 2'b00, 0, '0, 37'h1_2345_67A9);
      chk("R2 data load", rc_value, 37'h29);
      chk("R2 data clears inf", rc_inf, 0);

      // R6 load beats step
      step_once(2'b01, 1, 2'b00, 0, 6'd5, '0);
      chk("R6 load over step", rc_value, 5);

      // R7 repeat counter idle while loop busy
      step_once(2'b00, 0, 2'b10, 0, 6'd9, 37'h1F_FFFF_FFFF);
      step_once(2'b00, 0, 2'b01, 0, 6'd0, '0);
      step_once(2'b00, 0, 2'b11, 1, 6'd0, 37'h3F);
      chk("R7 repeat held", rc_value, 5);

      // R9 clear beats data load
      chk("R9 clear wins", lc_value, 0);
      step_once(2'b00, 0, 2'b10, 1, 6'd7, '0);
      chk("R9 clear over literal", lc_value, 0);

      // R8 decrement floor and data load
      step_once(2'b00, 0, 2'b01, 0, '0, '0);
      chk("R8 dec floor", lc_value, 0);
      step_once(2'b00, 0, 2'b11, 0, '0, 37'h0_0000_0042);
      chk("R8 data load", lc_value, 2);
      step_once(2'b00, 0, 2'b01, 0, '0, 37'h15_5555_5555);
      chk("R8 decrement", lc_value, 1);
      // R11 upper bits of read-back follow data_in
      chk("R11 readback", rd_loop_word, 37'h15_5555_5541);

      // random mix against the reference model
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] rc_c, lc_c;
         logic [DATA_W-1:0] dat;
         rc_c = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
         lc_c = 2'($urandom);
         dat  = {5'($urandom), 32'($urandom)};
         step_once(rc_c, 1'($urandom), lc_c, ($urandom_range(0, 9) == 0),
                   LIT_W'($urandom), dat);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule